// File: doc/BRIEF.md
# Four-Stream Chunked SHA-1 Sequencer

The block computes four independent SHA-1 digests at once from one stream of command frames. A frame opens with a one-byte opcode. A payload of pre-padded 512-bit chunks follows, and the chunks interleave the four messages: in each group, one chunk goes to each stream in turn. The opcode decides what happens to all four chaining states together. A first frame reseeds them with the standard SHA-1 initial values. A middle frame carries on from where the last frame left them. A last frame carries on in the same way and then announces that the digests are final.

Input arrives as 32-bit words under a valid/ready handshake. A start-of-frame flag marks the opcode beat. Each chunk is collected into a 16-word window, and the compression then runs at one SHA-1 round per clock. While it runs the input is held off. The four chaining states are always visible on a flat digest bus. A single-cycle strobe marks the moment they hold the final digests of a finishing frame.

Top module: `quad_hash_seq`

## Requirements
- R1: After reset, ready_o is 1, digest_valid_o is 0 and digest_o is all zeros.
- R2: A frame is one beat with sof_i=1 that carries the opcode in data_i[7:0], followed by STREAMS*ROUNDS chunks of 16 words each. Within a chunk, the first word is the most significant (SHA-1 word W0). Chunk n of the frame belongs to stream n mod STREAMS.
- R3: Opcode 0xAA loads the SHA-1 initial value 67452301 efcdab89 98badcfe 10325476 c3d2e1f0 into every stream state before the frame's first chunk is compressed.
- R4: Opcode 0xBB compresses each chunk onto the state that its stream holds from earlier frames. After reset that state is zero.
- R5: Opcode 0xCC chains like 0xBB. One cycle after the writeback of its final chunk, digest_valid_o is high for exactly one cycle. Stream k's digest is digest_o[160*k +: 160], with SHA-1 word H0 in the most significant 32 bits.
- R6: A start beat with any other opcode is ignored. The beats without sof_i that follow it are also dropped until the next valid start beat. ready_o stays high and digest_o does not change.
- R7: Once a chunk's sixteenth word is accepted, ready_o stays low for exactly 81 cycles (80 rounds plus one writeback) and then returns high.
- R8: digest_valid_o never rises during or after a frame with opcode 0xAA or 0xBB.
- R9: After each chunk's writeback, digest_o shows that stream's state as state + compress(state, chunk), summed word by word modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input word valid |
| sof_i | input | 1 | Marks the opcode beat of a frame |
| data_i | input | 32 | Opcode in bits 7:0 on the start beat, otherwise a message word |
| ready_o | output | 1 | Input word accepted when high together with valid_i |
| digest_o | output | 160*STREAMS | Chaining state of every stream, stream 0 in the low bits |
| digest_valid_o | output | 1 | One-cycle strobe after a last frame completes |

## Verification
The bench uses the default STREAMS=4 and ROUNDS=5, so every frame carries twenty chunks. Each stream index wraps five times per frame, and chaining crosses frame boundaries, including back-to-back last frames and a middle frame straight after reset. A fixed-seed random payload, with random idle gaps on valid_i, is compared against a reference SHA-1 in the bench. A directed chunk holding the padded message "abc" pins the digest to the published answer after the first compression.

// File: rtl/quad_hash_pkg.sv
package quad_hash_pkg;
  localparam int WORD_W      = 32;
  localparam int STATE_W     = 160;
  localparam int CHUNK_WORDS = 16;
  localparam int SHA_ROUNDS  = 80;
  localparam logic [STATE_W-1:0] SHA_IV =
    160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;

  typedef enum logic [7:0] {
    OP_FIRST = 8'hAA,
    OP_MID   = 8'hBB,
    OP_LAST  = 8'hCC
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_COMP, ST_WB} st_e;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [STATE_W-1:0] round_step(input logic [STATE_W-1:0] v,
                                                    input logic [6:0] t,
                                                    input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] a, b, c, d, e, f, k, tmp;
    {a, b, c, d, e} = v;
    if (t < 7'd20) begin
      f = (b & c) | (~b & d);
      k = 32'h5a827999;
    end else if (t < 7'd40) begin
      f = b ^ c ^ d;
      k = 32'h6ed9eba1;
    end else if (t < 7'd60) begin
      f = (b & c) | (b & d) | (c & d);
      k = 32'h8f1bbcdc;
    end else begin
      f = b ^ c ^ d;
      k = 32'hca62c1d6;
    end
    tmp = rotl(a, 5) + f + e + k + w;
    return {tmp, a, rotl(b, 30), c, d};
  endfunction

  function automatic logic [STATE_W-1:0] lane_add(input logic [STATE_W-1:0] x,
                                                  input logic [STATE_W-1:0] y);
    logic [STATE_W-1:0] r;
    for (int i = 0; i < STATE_W / WORD_W; i++)
      r[i*WORD_W +: WORD_W] = x[i*WORD_W +: WORD_W] + y[i*WORD_W +: WORD_W];
    return r;
  endfunction
endpackage

// File: rtl/quad_hash_ctrl.sv
module quad_hash_ctrl
  import quad_hash_pkg::*;
#(
  parameter int STREAMS = 4,
  parameter int ROUNDS  = 5,
  localparam int TOTAL  = STREAMS * ROUNDS,
  localparam int CNT_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int SEL_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic [7:0]       op_i,
  output logic             ready_o,
  output logic             fill_o,
  output logic             init_all_o,
  output logic             start_o,
  output logic             step_o,
  output logic [6:0]       t_o,
  output logic             wr_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             done_o
);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(STREAMS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);
  localparam logic [6:0]       T_LAST   = 7'(SHA_ROUNDS - 1);
  localparam logic [3:0]       W_LAST   = 4'(CHUNK_WORDS - 1);

  st_e              state_q;
  logic [3:0]       word_q;
  logic [CNT_W-1:0] chunk_q;
  logic [SEL_W-1:0] sel_q;
  logic [6:0]       t_q;
  logic             last_q, done_q;
  logic             accept, op_ok;

  assign ready_o    = (state_q == ST_IDLE) || (state_q == ST_FILL);
  assign accept     = valid_i && ready_o;
  assign op_ok      = (op_i == OP_FIRST) || (op_i == OP_MID) || (op_i == OP_LAST);
  assign init_all_o = (state_q == ST_IDLE) && accept && sof_i && (op_i == OP_FIRST);
  assign fill_o     = (state_q == ST_FILL) && accept;
  assign start_o    = fill_o && (word_q == W_LAST);
  assign step_o     = (state_q == ST_COMP);
  assign wr_o       = (state_q == ST_WB);
  assign t_o        = t_q;
  assign sel_o      = sel_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      chunk_q <= '0;
      sel_q   <= '0;
      t_q     <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept && sof_i && op_ok) begin
          state_q <= ST_FILL;
          last_q  <= (op_i == OP_LAST);
          word_q  <= '0;
          chunk_q <= '0;
          sel_q   <= '0;
        end
        ST_FILL: if (fill_o) begin
          word_q <= word_q + 4'd1;
          if (word_q == W_LAST) begin
            state_q <= ST_COMP;
            t_q     <= '0;
          end
        end
        ST_COMP: begin
          t_q <= t_q + 7'd1;
          if (t_q == T_LAST) state_q <= ST_WB;
        end
        ST_WB: begin
          sel_q  <= (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
          word_q <= '0;
          if (chunk_q == CNT_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= last_q;
          end else begin
            chunk_q <= chunk_q + 1'b1;
            state_q <= ST_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> last_q);
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_wb_after_rounds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && t_q == T_LAST) |=> wr_o);
  p_bad_op_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && valid_i && sof_i && !op_ok) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/quad_hash_sched.sv
module quad_hash_sched
  import quad_hash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] w_o
);
  logic [WORD_W-1:0] win_q [CHUNK_WORDS];
  logic [WORD_W-1:0] fresh;

  // next schedule word from the sliding 16-word window
  assign fresh = rotl(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
  assign w_o   = win_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CHUNK_WORDS; i++) win_q[i] <= '0;
    end else if (load_i || step_i) begin
      for (int i = 0; i < CHUNK_WORDS - 1; i++) win_q[i] <= win_q[i+1];
      win_q[CHUNK_WORDS-1] <= load_i ? word_i : fresh;
    end
  end

  p_load_step_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));
endmodule

// File: rtl/quad_hash_round.sv
module quad_hash_round
  import quad_hash_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               step_i,
  input  logic [6:0]         t_i,
  input  logic [WORD_W-1:0]  w_i,
  output logic [STATE_W-1:0] work_o
);
  logic [STATE_W-1:0] work_q;

  assign work_o = work_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     work_q <= '0;
    else if (init_i) work_q <= state_i;
    else if (step_i) work_q <= round_step(work_q, t_i, w_i);
  end

  p_init_step_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_i && step_i));
endmodule

// File: rtl/quad_hash_bank.sv
module quad_hash_bank
  import quad_hash_pkg::*;
#(
  parameter int STREAMS = 4,
  localparam int SEL_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       init_all_i,
  input  logic                       wr_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [STATE_W-1:0]         work_i,
  output logic [STATE_W-1:0]         rd_o,
  output logic [STREAMS*STATE_W-1:0] digests_o
);
  logic [STATE_W-1:0] st_q [STREAMS];

  assign rd_o = st_q[sel_i];

  for (genvar k = 0; k < STREAMS; k++) begin : g_lane
    assign digests_o[k*STATE_W +: STATE_W] = st_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              st_q[k] <= '0;
      else if (init_all_i)                      st_q[k] <= SHA_IV;
      else if (wr_i && sel_i == SEL_W'(k))      st_q[k] <= lane_add(st_q[k], work_i);
    end
  end

  p_init_no_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_all_i |-> !wr_i);
  p_rd_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !init_all_i && $stable(sel_i)) |=> $stable(rd_o));
endmodule

// File: rtl/quad_hash_seq.sv
module quad_hash_seq
  import quad_hash_pkg::*;
#(
  parameter int STREAMS = 4,
  parameter int ROUNDS  = 5,
  localparam int SEL_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       sof_i,
  input  logic [WORD_W-1:0]          data_i,
  output logic                       ready_o,
  output logic [STREAMS*STATE_W-1:0] digest_o,
  output logic                       digest_valid_o
);
  logic               fill, init_all, start, step, wr;
  logic [6:0]         t;
  logic [SEL_W-1:0]   sel;
  logic [WORD_W-1:0]  w;
  logic [STATE_W-1:0] work, rd;

  quad_hash_ctrl #(.STREAMS(STREAMS), .ROUNDS(ROUNDS)) u_ctrl (
    .clk_i, .rst_ni, .valid_i, .sof_i,
    .op_i      (data_i[7:0]),
    .ready_o,
    .fill_o    (fill),
    .init_all_o(init_all),
    .start_o   (start),
    .step_o    (step),
    .t_o       (t),
    .wr_o      (wr),
    .sel_o     (sel),
    .done_o    (digest_valid_o)
  );

  quad_hash_sched u_sched (
    .clk_i, .rst_ni,
    .load_i(fill),
    .word_i(data_i),
    .step_i(step),
    .w_o   (w)
  );

  quad_hash_round u_round (
    .clk_i, .rst_ni,
    .init_i (start),
    .state_i(rd),
    .step_i (step),
    .t_i    (t),
    .w_i    (w),
    .work_o (work)
  );

  quad_hash_bank #(.STREAMS(STREAMS)) u_bank (
    .clk_i, .rst_ni,
    .init_all_i(init_all),
    .wr_i      (wr),
    .sel_i     (sel),
    .work_i    (work),
    .rd_o      (rd),
    .digests_o (digest_o)
  );

  p_no_accept_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !ready_o);
endmodule

// File: tb/quad_hash_seq_tb.sv
module quad_hash_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STREAMS = 4;
  localparam int ROUNDS  = 5;
  localparam int TOTAL   = STREAMS * ROUNDS;
  localparam logic [159:0] IV  = 160'h67452301efcdab8998badcfe10325476c3d2e1f0;
  localparam logic [159:0] KAT = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;

  logic clk = 1'b0;
  logic rst_n, valid, sof;
  logic [31:0] data;
  logic ready;
  logic [STREAMS*160-1:0] digest;
  logic digest_valid;

  int checks = 0, errors = 0;
  int dones_seen = 0, dones_exp = 0;
  int low_run = 0;
  bit gaps_on = 1'b0;
  logic [159:0] model [STREAMS];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_hash_seq #(.STREAMS(STREAMS), .ROUNDS(ROUNDS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .data_i(data),
    .ready_o(ready), .digest_o(digest), .digest_valid_o(digest_valid)
  );

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_sha1(input logic [159:0] h, input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, tmp;
    for (int i = 0; i < 80; i++) begin
      if (i < 16) w[i] = blk[511-32*i -: 32];
      else w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    end
    {a, b, c, d, e} = h;
    for (int i = 0; i < 80; i++) begin
      case (i / 20)
        0: begin f = (b & c) | (~b & d); k = 32'h5a827999; end
        1: begin f = b ^ c ^ d; k = 32'h6ed9eba1; end
        2: begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
        default: begin f = b ^ c ^ d; k = 32'hca62c1d6; end
      endcase
      tmp = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  // R7: every busy stretch lasts 80 rounds plus one writeback
  always @(negedge clk) begin
    if (rst_n) begin
      if (digest_valid) dones_seen++;
      if (!ready) low_run++;
      else if (low_run > 0) begin
        check(low_run == 81, "R7 busy length", 160'(low_run), 160'd81);
        low_run = 0;
      end
    end
  end

  task automatic put_beat(input logic s, input logic [31:0] d);
    if (gaps_on && $urandom_range(0, 5) == 0)
      repeat ($urandom_range(1, 3)) @(negedge clk);
    @(negedge clk);
    valid = 1'b1; sof = s; data = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    #1;
    valid = 1'b0; sof = 1'b0; data = $urandom;
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < STREAMS; s++)
      check(digest[160*s +: 160] === model[s], req, digest[160*s +: 160], model[s]);
  endtask

  // kat=1 fills every chunk with the padded message "abc"
  task automatic send_frame(input logic [7:0] op, input bit kat);
    logic [511:0] blk;
    logic [31:0] wd;
    put_beat(1'b1, {24'h5a5a5a, op});
    if (op == 8'hAA) for (int s = 0; s < STREAMS; s++) model[s] = IV;
    for (int c = 0; c < TOTAL; c++) begin
      for (int i = 0; i < 16; i++) begin
        if (kat) wd = (i == 0) ? 32'h61626380 : (i == 15) ? 32'h00000018 : 32'h0;
        else wd = $urandom;
        blk[511-32*i -: 32] = wd;
        put_beat(1'b0, wd);
      end
      model[c % STREAMS] = ref_sha1(model[c % STREAMS], blk);
      if (kat && c == 0) begin
        wait_ready();
        check(digest[159:0] === KAT, "R3 first chunk from IV", digest[159:0], KAT);
        check(digest[319:160] === IV, "R3 stream1 seeded", digest[319:160], IV);
      end
    end
    wait_ready();
    if (op == 8'hCC) begin
      dones_exp++;
      check(digest_valid === 1'b1, "R5 strobe", 160'(digest_valid), 160'd1);
      check_all("R5 final digest");
      @(negedge clk);
      check(digest_valid === 1'b0, "R5 single cycle", 160'(digest_valid), 160'd0);
    end else begin
      check(digest_valid === 1'b0, "R8 no strobe", 160'(digest_valid), 160'd0);
      check_all(op == 8'hAA ? "R3 chained state" : "R4 chained state");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [STREAMS*160-1:0] snap;
    void'($urandom(32'd4242));
    rst_n = 1'b0; valid = 1'b0; sof = 1'b0; data = '0;
    for (int s = 0; s < STREAMS; s++) model[s] = '0;
    repeat (3) @(negedge clk);
    check(ready === 1'b1, "R1 ready", 160'(ready), 160'd1);
    check(digest_valid === 1'b0, "R1 strobe", 160'(digest_valid), 160'd0);
    check(digest === '0, "R1 digest", digest[159:0], 160'd0);
    rst_n = 1'b1;

    send_frame(8'hBB, 1'b0);            // R4 from reset state
    send_frame(8'hAA, 1'b1);            // R3, R2 directed
    send_frame(8'hCC, 1'b0);            // R5, R9

    // R6: unknown opcode and following stray words
    snap = digest;
    put_beat(1'b1, 32'h0000005a);
    for (int i = 0; i < 10; i++) put_beat(1'b0, $urandom);
    put_beat(1'b1, 32'h00000000);
    @(negedge clk);
    check(ready === 1'b1, "R6 ready held", 160'(ready), 160'd1);
    check(digest === snap, "R6 digest unchanged", digest[159:0], snap[159:0]);
    check(digest_valid === 1'b0, "R6 no strobe", 160'(digest_valid), 160'd0);

    gaps_on = 1'b1;
    send_frame(8'hBB, 1'b0);            // R6 state kept, R4
    send_frame(8'hAA, 1'b0);
    send_frame(8'hBB, 1'b0);
    send_frame(8'hCC, 1'b0);
    send_frame(8'hCC, 1'b0);            // R5 back-to-back last frames
    repeat (5) @(negedge clk);
    check(dones_seen == dones_exp, "R8 strobe count", 160'(dones_seen), 160'(dones_exp));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule